// File: doc/BRIEF.md
# Segmented write reassembly target with two consumer ports

This block sits on the target side of a narrow write bus that uses a request/acknowledge handshake. Each bus write carries one byte and an address. The block splits the low part of that address into a port number and a segment number. It stores each byte in an assembly register that belongs to the selected port. When the highest segment of a port arrives, the whole wide word goes to that port's output register in one step. A functional module then reads the word as if it had been written in a single piece.

Two ports are served. Port 0 is 64 bits wide and works like a signal. A finished word overwrites the output and raises a one-cycle update pulse. The bus is never held off for it. Port 1 is 32 bits wide and works like a one-entry queue. A finished word stays valid until the consumer takes it. Until then, the bus is not acknowledged for any further segment of that port.

A configuration input gives the bit position where the port field starts. Bits above the port field are routing bits and are ignored, because routing to this target has already been done.

Top module: `bus_target_adapter`

## Requirements
- R1: After synchronous reset, `w0_data` and `w1_data` are zero, `w0_upd` and `w1_valid` are low, and `ack` is low while `req` is low.
- R2: With `cfg_split` = S (0..3), the segment number is `addr[S-1:0]` (zero when S is 0). The port number is `addr[S+1:S]`. Address bits above S+1 have no effect on the result.
- R3: A byte written to segment N of a port lands in bits [8N+7:8N] of that port's word.
- R4: A word is presented only when segment 7 (port 0) or segment 3 (port 1) is written. The new output is visible in the cycle after the accepted write of that segment. Outputs do not change on any other write.
- R5: Port 0 never withholds `ack`. Each finished word replaces `w0_data` and raises `w0_upd` for exactly one cycle.
- R6: On port 1, a finished word sets `w1_valid`. `w1_valid` and `w1_data` hold until `w1_take` is sampled high at a clock edge. `w1_valid` is low from the following cycle.
- R7: While `w1_valid` is high, `ack` stays low for a write to segments 0..3 of port 1. The write is accepted once the word has been taken.
- R8: A write to port 2 or port 3, or to segments 4..7 of port 1, is acknowledged in the same cycle, even while port 1 is holding a word. It changes no output and no stored byte.
- R9: `ack` is combinational. It is high only when `req` is high. A transfer takes place at a rising edge where both `req` and `ack` are high.
- R10: Bytes of a port are kept between words and may be written in any order. Writing only the highest segment presents the previously stored bytes together with the new top byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split | input | 2 | Bit position where the port field starts; the segment field lies below it |
| req | input | 1 | Write request |
| addr | input | 5 | Write address |
| wdata | input | 8 | Write byte |
| ack | output | 1 | Write acknowledge |
| w0_data | output | 64 | Port 0 word (signal style) |
| w0_upd | output | 1 | One-cycle pulse when a new port 0 word is loaded |
| w1_data | output | 32 | Port 1 word (queue style) |
| w1_valid | output | 1 | Port 1 holds a word not yet taken |
| w1_take | input | 1 | Consumer takes the port 1 word |

## Verification
The bench checks that an early segment never produces a word. A design that completes on the wrong segment would pulse early or carry bytes from the wrong place. It writes segment 7 to port 1 just before segment 3. A decoder that truncates the segment field would then finish the word early with a junk byte. It drives writes to missing ports, using segment bits that match port 0's top segment. A design that aliases those writes would finish port 0's word or corrupt it. It keeps a port 1 request pending while a word is held. This exposes a design that overwrites the held word, or one that never releases the bus after the take. A second split setting, with the routing bit set, catches a decoder that ignores `cfg_split` or lets the routing bits leak into the port number.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic {DELIV_REG = 1'b0, DELIV_QUEUE = 1'b1} deliv_e;

  function automatic int seg_count(input int width, input int data_w);
    return width / data_w;
  endfunction
endpackage

// File: rtl/bta_decode.sv
module bta_decode #(
  parameter int ADDR_W  = 5,
  parameter int SEG_W   = 3,
  parameter int PORT_W  = 2,
  parameter int SPLIT_W = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SPLIT_W-1:0] cfg_split,
  output logic [SEG_W-1:0]   seg,
  output logic [PORT_W-1:0]  port
);
  always_comb begin
    seg  = '0;
    port = '0;
    for (int i = 0; i < SEG_W; i++) begin
      if (i < int'(cfg_split)) seg[i] = addr[i];
    end
    for (int j = 0; j < PORT_W; j++) begin
      if (int'(cfg_split) + j < ADDR_W) port[j] = addr[int'(cfg_split) + j];
    end
  end
endmodule

// File: rtl/bta_lane.sv
module bta_lane
  import bta_pkg::*;
#(
  parameter int     WIDTH  = 64,
  parameter int     DATA_W = 8,
  parameter int     SEG_W  = 3,
  parameter deliv_e MODE   = DELIV_REG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  seg,
  input  logic [DATA_W-1:0] wbyte,
  input  logic              take,
  output logic              seg_ok,
  output logic              busy,
  output logic [WIDTH-1:0]  data,
  output logic              flag
);
  localparam int SEGS = seg_count(WIDTH, DATA_W);
  localparam int LAST = SEGS - 1;

  logic [SEGS-1:0][DATA_W-1:0] asm_q;
  logic [SEGS-1:0][DATA_W-1:0] word;
  logic                        complete;

  assign seg_ok   = ({1'b0, seg} < (SEG_W+1)'(SEGS));
  assign complete = wr_en && (seg == SEG_W'(LAST));

  for (genvar k = 0; k < SEGS; k++) begin : g_byte
    assign word[k] = (wr_en && seg == SEG_W'(k)) ? wbyte : asm_q[k];
    always_ff @(posedge clk) begin
      if (rst) asm_q[k] <= '0;
      else if (wr_en && seg == SEG_W'(k)) asm_q[k] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      flag <= 1'b0;
    end else if (complete) begin
      data <= word;
      flag <= 1'b1;
    end else if (MODE == DELIV_REG || take) begin
      flag <= 1'b0;
    end
  end

  assert_out_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !flag |-> $stable(data));

  if (MODE == DELIV_QUEUE) begin : g_queue
    assign busy = flag;

    assert_hold_until_take_R6: assert property (@(posedge clk) disable iff (rst)
      flag && !take |=> flag && $stable(data));

    assert_no_write_when_full_R7: assert property (@(posedge clk) disable iff (rst)
      flag |-> !wr_en);
  end else begin : g_reg
    assign busy = 1'b0;

    assert_pulse_after_load_R5: assert property (@(posedge clk) disable iff (rst)
      flag && !wr_en |=> !flag);
  end
endmodule

// File: rtl/bus_target_adapter.sv
module bus_target_adapter
  import bta_pkg::*;
#(
  parameter int     ADDR_W = 5,
  parameter int     DATA_W = 8,
  parameter int     W0     = 64,
  parameter int     W1     = 32,
  parameter deliv_e MODE0  = DELIV_REG,
  parameter deliv_e MODE1  = DELIV_QUEUE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_split,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [W0-1:0]     w0_data,
  output logic              w0_upd,
  output logic [W1-1:0]     w1_data,
  output logic              w1_valid,
  input  logic              w1_take
);
  localparam int SEG_W  = $clog2(seg_count(W0, DATA_W));
  localparam int PORT_W = 2;

  logic [SEG_W-1:0]  seg;
  logic [PORT_W-1:0] port;
  logic              ok0, ok1, busy0, busy1;
  logic              sel0, sel1, stall, xfer;

  bta_decode #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PORT_W(PORT_W), .SPLIT_W(2)) u_dec (
    .addr(addr), .cfg_split(cfg_split), .seg(seg), .port(port)
  );

  assign sel0  = (port == PORT_W'(0)) && ok0;
  assign sel1  = (port == PORT_W'(1)) && ok1;
  assign stall = (sel0 && busy0) || (sel1 && busy1);
  assign ack   = req && !stall;
  assign xfer  = req && ack;

  bta_lane #(.WIDTH(W0), .DATA_W(DATA_W), .SEG_W(SEG_W), .MODE(MODE0)) u_lane0 (
    .clk(clk), .rst(rst), .wr_en(xfer && sel0), .seg(seg), .wbyte(wdata),
    .take(1'b0), .seg_ok(ok0), .busy(busy0), .data(w0_data), .flag(w0_upd)
  );

  bta_lane #(.WIDTH(W1), .DATA_W(DATA_W), .SEG_W(SEG_W), .MODE(MODE1)) u_lane1 (
    .clk(clk), .rst(rst), .wr_en(xfer && sel1), .seg(seg), .wbyte(wdata),
    .take(w1_take), .seg_ok(ok1), .busy(busy1), .data(w1_data), .flag(w1_valid)
  );

  assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    ack |-> req);

  assert_discard_acked_R8: assert property (@(posedge clk) disable iff (rst)
    req && (port >= PORT_W'(2)) |-> ack);

  assert_reg_port_never_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    req && (port == PORT_W'(0)) |-> ack);
endmodule

// File: tb/bus_target_adapter_tb.sv
module bus_target_adapter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_split = 2'd3;
  logic        req = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack;
  logic [63:0] w0_data;
  logic        w0_upd;
  logic [31:0] w1_data;
  logic        w1_valid;
  logic        w1_take = 1'b0;

  int checks = 0;
  int errors = 0;
  int last_wait = 0;
  logic [63:0] exp0;

  always #4 clk = ~clk;

  bus_target_adapter u_dut (
    .clk(clk), .rst(rst), .cfg_split(cfg_split), .req(req), .addr(addr),
    .wdata(wdata), .ack(ack), .w0_data(w0_data), .w0_upd(w0_upd),
    .w1_data(w1_data), .w1_valid(w1_valid), .w1_take(w1_take)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [4:0] mk_addr(input int split, input int port, input int seg, input int agent);
    return 5'((agent << (split + 2)) | (port << split) | seg);
  endfunction

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    req = 1'b1; addr = a; wdata = d;
    #1;
    last_wait = 0;
    while (!ack) begin
      @(posedge clk); #1;
      last_wait++;
    end
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic send_word(input int port, input int nseg, input logic [63:0] v, input int agent);
    for (int s = 0; s < nseg; s++)
      bus_write(mk_addr(int'(cfg_split), port, s, agent), v[8*s +: 8]);
  endtask

  task automatic t_reset();
    chk("R1 w0_data", w0_data, 64'd0);
    chk("R1 w0_upd", {63'd0, w0_upd}, 64'd0);
    chk("R1 w1_data", {32'd0, w1_data}, 64'd0);
    chk("R1 w1_valid", {63'd0, w1_valid}, 64'd0);
    chk("R9 ack idle", {63'd0, ack}, 64'd0);
  endtask

  task automatic t_reg_words();
    logic [63:0] a = 64'h0123_4567_89AB_CDEF;
    logic [63:0] b = 64'hFEDC_BA98_7654_3210;
    int worst = 0;
    send_word(0, 7, a, 0);
    chk("R4 no word before last seg", {63'd0, w0_upd}, 64'd0);
    chk("R4 data unchanged before last seg", w0_data, 64'd0);
    bus_write(mk_addr(3, 0, 7, 0), a[63:56]);
    chk("R5 update pulse", {63'd0, w0_upd}, 64'd1);
    chk("R3 byte placement word A", w0_data, a);
    step();
    chk("R5 pulse one cycle", {63'd0, w0_upd}, 64'd0);
    chk("R5 data held", w0_data, a);
    for (int s = 0; s < 8; s++) begin
      bus_write(mk_addr(3, 0, s, 0), b[8*s +: 8]);
      if (last_wait > worst) worst = last_wait;
    end
    chk("R5 never stalled", 64'(worst), 64'd0);
    chk("R3 word B", w0_data, b);
    exp0 = b;
  endtask

  task automatic t_reorder();
    bus_write(mk_addr(3, 0, 7, 0), 8'h5A);
    exp0[63:56] = 8'h5A;
    chk("R10 top-only write pulse", {63'd0, w0_upd}, 64'd1);
    chk("R10 stale bytes kept", w0_data, exp0);
    bus_write(mk_addr(3, 0, 3, 0), 8'h11);
    step();
    chk("R4 no update on seg 3", w0_data, exp0);
    bus_write(mk_addr(3, 0, 7, 0), 8'h22);
    exp0[31:24] = 8'h11;
    exp0[63:56] = 8'h22;
    chk("R10 out of order word", w0_data, exp0);
  endtask

  task automatic t_queue();
    logic [31:0] qa = 32'hDEAD_BEEF;
    logic [31:0] qb = 32'hCAFE_F00D;
    send_word(1, 4, {32'd0, qa}, 0);
    chk("R6 valid set", {63'd0, w1_valid}, 64'd1);
    chk("R6 data A", {32'd0, w1_data}, {32'd0, qa});
    req = 1'b1; addr = mk_addr(3, 1, 0, 0); wdata = qb[7:0];
    #1;
    chk("R7 ack withheld", {63'd0, ack}, 64'd0);
    step();
    chk("R7 ack still withheld", {63'd0, ack}, 64'd0);
    chk("R6 held word", {32'd0, w1_data}, {32'd0, qa});
    chk("R6 still valid", {63'd0, w1_valid}, 64'd1);
    w1_take = 1'b1;
    step();
    w1_take = 1'b0;
    chk("R6 valid cleared after take", {63'd0, w1_valid}, 64'd0);
    chk("R7 ack after take", {63'd0, ack}, 64'd1);
    step();
    req = 1'b0;
    for (int s = 1; s < 4; s++) bus_write(mk_addr(3, 1, s, 0), qb[8*s +: 8]);
    chk("R6 word B valid", {63'd0, w1_valid}, 64'd1);
    chk("R3 word B on port 1", {32'd0, w1_data}, {32'd0, qb});
    w1_take = 1'b1;
    step();
    w1_take = 1'b0;
  endtask

  task automatic t_discard();
    logic [63:0] c = 64'h1111_2222_3333_4444;
    logic [31:0] q = 32'h0A0B_0C0D;
    send_word(0, 7, c, 0);
    bus_write(5'b10111, 8'hEE);
    chk("R8 port2 ack immediate", 64'(last_wait), 64'd0);
    chk("R8 port2 no effect", {63'd0, w0_upd}, 64'd0);
    bus_write(5'b11111, 8'hEE);
    chk("R8 port3 ack immediate", 64'(last_wait), 64'd0);
    chk("R8 port0 unchanged", w0_data, exp0);
    bus_write(mk_addr(3, 0, 7, 0), c[63:56]);
    chk("R8 assembly not disturbed", w0_data, c);
    send_word(1, 3, {32'd0, q}, 0);
    bus_write(mk_addr(3, 1, 7, 0), 8'h99);
    step();
    chk("R8 port1 seg7 no word", {63'd0, w1_valid}, 64'd0);
    bus_write(mk_addr(3, 1, 3, 0), q[31:24]);
    chk("R8 port1 word intact", {32'd0, w1_data}, {32'd0, q});
    bus_write(mk_addr(3, 1, 5, 0), 8'h77);
    chk("R8 out-of-range acked while full", 64'(last_wait), 64'd0);
    chk("R8 held word intact", {32'd0, w1_data}, {32'd0, q});
    w1_take = 1'b1;
    step();
    w1_take = 1'b0;
  endtask

  task automatic t_split2();
    logic [31:0] v = 32'h1357_9BDF;
    cfg_split = 2'd2;
    step();
    send_word(1, 4, {32'd0, v}, 1);
    chk("R2 split 2 valid", {63'd0, w1_valid}, 64'd1);
    chk("R2 split 2 data", {32'd0, w1_data}, {32'd0, v});
    bus_write(mk_addr(2, 2, 3, 1), 8'h55);
    chk("R2 port2 at split 2 acked", 64'(last_wait), 64'd0);
    chk("R2 port0 untouched", {63'd0, w0_upd}, 64'd0);
    w1_take = 1'b1;
    step();
    w1_take = 1'b0;
    cfg_split = 2'd3;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    step();
    t_reset();
    t_reg_words();
    t_reorder();
    t_queue();
    t_discard();
    t_split2();
    repeat (2) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule